// File: doc/BRIEF.md
# Supply Low-Voltage Detector Mode Controller

This block turns the digital outputs of supply-voltage comparators into a low-voltage reset and a latched interrupt request. It receives three comparator flags, already synchronized to its clock. One flag compares the supply against a single detection level. The other two compare it against a high level and a low level, where the low level sits below the high one. A flag reads 1 when the supply is above its level. A strobe, `cmp_valid`, marks the cycles in which the flags hold a fresh sample. The controller acts only on those cycles.

A two-bit operating mode picks the behaviour, and each mode uses its own thresholds:
- `2'b00`, reset-only: the reset follows the single level.
- `2'b01`, warning then reset: an interrupt is raised when the supply drops below the high level, and the reset is asserted when it drops below the low level.
- `2'b10`, interrupt-only: the reset is held only until the supply first rises above the single level. After that, every crossing of that level in either direction raises an interrupt.
- `2'b11`, disabled: both outputs are kept inactive.

The interrupt request is a sticky flag. Software clears it with the `irq_clr` strobe.

Top module: `lvd_mode_ctrl`

## Requirements
- R1: After reset, `lvd_rst` is 1 and `lvd_irq` is 0. Both keep these values until the first cycle in which `cmp_valid` is 1.
- R2: In mode 2'b00, each valid sample sets `lvd_rst` to the inverse of `above_det` on the following clock edge. No interrupt is raised in this mode.
- R3: In mode 2'b01, a valid sample with `above_lo` = 0 asserts `lvd_rst` on the following edge.
- R4: In mode 2'b01, an asserted `lvd_rst` is released only by a valid sample with `above_hi` = 1. A sample with `above_lo` = 1 and `above_hi` = 0 leaves it unchanged.
- R5: In mode 2'b01, a valid sample with `above_hi` = 0 sets `lvd_irq` when the previous valid sample had `above_hi` = 1.
- R6: In mode 2'b10, `lvd_rst` stays asserted until a valid sample with `above_det` = 1 releases it. While the mode stays 2'b10, it is not asserted again.
- R7: In mode 2'b10, once the reset has been released, `lvd_irq` is set by any valid sample whose `above_det` differs from the previous valid sample. The sample that releases the reset raises no interrupt.
- R8: `lvd_irq` stays set until a cycle with `irq_clr` = 1 clears it on the following edge. If a clear and a new event arrive in the same cycle, the flag stays set.
- R9: In mode 2'b11, `lvd_irq` is 0 after every clock edge, and each valid sample sets `lvd_rst` to 0.
- R10: Cycles with `cmp_valid` = 0 leave `lvd_rst` unchanged and raise no interrupt, whatever the flag values are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| cmp_valid | input | 1 | Comparator flags hold a fresh sample |
| above_det | input | 1 | Supply above the single detection level |
| above_hi | input | 1 | Supply above the high level |
| above_lo | input | 1 | Supply above the low level |
| mode | input | 2 | Operating mode: 00 reset, 01 interrupt+reset, 10 interrupt, 11 off |
| irq_clr | input | 1 | Clears the interrupt request |
| lvd_rst | output | 1 | Active-high low-voltage reset |
| lvd_irq | output | 1 | Latched interrupt request |

## Verification
The bench drives the supply through the band between the low and high levels in both directions. A design that released the reset on the low level, instead of waiting for the high level, would drop `lvd_rst` too early there. In interrupt-only mode, the sample that releases the reset is checked for a spurious interrupt. The same mode is also checked to confirm that a fall never re-asserts the reset. A clear that arrives together with a new event must leave the flag set; a design that gave the clear priority would lose that event. Cycles without `cmp_valid`, in which the flags are deliberately wrong, would expose a controller that samples on every clock.

// File: rtl/lvd_mode_ctrl.sv
module lvd_mode_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmp_valid,
  input  logic       above_det,
  input  logic       above_hi,
  input  logic       above_lo,
  input  logic [1:0] mode,
  input  logic       irq_clr,
  output logic       lvd_rst,
  output logic       lvd_irq
);
  localparam logic [1:0] M_RST = 2'b00;
  localparam logic [1:0] M_IRST = 2'b01;
  localparam logic [1:0] M_IRQ = 2'b10;
  localparam logic [1:0] M_OFF = 2'b11;

  logic rst_q, irq_q, seen_q, prev_det_q, prev_hi_q;
  logic rst_d, evt;

  always_comb begin
    rst_d = rst_q;
    unique case (mode)
      M_RST:  rst_d = ~above_det;
      M_IRST: if (!above_lo) rst_d = 1'b1;
              else if (above_hi) rst_d = 1'b0;
      M_IRQ:  if (above_det) rst_d = 1'b0;
      M_OFF:  rst_d = 1'b0;
    endcase
  end

  always_comb begin
    evt = 1'b0;
    if (cmp_valid && seen_q) begin
      if (mode == M_IRST) evt = prev_hi_q & ~above_hi;
      else if (mode == M_IRQ) evt = ~rst_q & (above_det ^ prev_det_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q      <= 1'b1;
      seen_q     <= 1'b0;
      prev_det_q <= 1'b0;
      prev_hi_q  <= 1'b0;
    end else if (cmp_valid) begin
      rst_q      <= rst_d;
      seen_q     <= 1'b1;
      prev_det_q <= above_det;
      prev_hi_q  <= above_hi;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else if (mode == M_OFF) irq_q <= 1'b0;
    else irq_q <= evt | (irq_q & ~irq_clr);
  end

  assign lvd_rst = rst_q;
  assign lvd_irq = irq_q;

  assert_rst_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && mode == M_RST) |=> (lvd_rst == !$past(above_det)));

  assert_low_trips_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && mode == M_IRST && !above_lo) |=> lvd_rst);

  assert_band_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (lvd_rst && cmp_valid && mode == M_IRST && above_lo && !above_hi) |=> lvd_rst);

  assert_no_reassert_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!lvd_rst && mode == M_IRQ) |=> !lvd_rst);

  assert_irq_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (lvd_irq && !irq_clr && mode != M_OFF) |=> lvd_irq);

  assert_off_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_OFF) |=> !lvd_irq);

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmp_valid) |=> $stable(lvd_rst));
endmodule

// File: tb/sim_lvd_mode_ctrl.sv
module sim_lvd_mode_ctrl;
  logic clk = 1'b0, rst_n = 1'b0, vld = 1'b0, det = 1'b0, hi = 1'b0, lo = 1'b0, clr = 1'b0;
  logic [1:0] mode = 2'b00;
  logic lvd_rst, lvd_irq;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  lvd_mode_ctrl u0 (.clk(clk), .rst_n(rst_n), .cmp_valid(vld), .above_det(det),
    .above_hi(hi), .above_lo(lo), .mode(mode), .irq_clr(clr),
    .lvd_rst(lvd_rst), .lvd_irq(lvd_irq));

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] m);
    @(negedge clk); rst_n = 1'b0; vld = 1'b0; clr = 1'b0; mode = m;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic smp(input logic d, input logic h, input logic l, input logic c);
    @(negedge clk); det = d; hi = h; lo = l; clr = c; vld = 1'b1;
    @(negedge clk); vld = 1'b0; clr = 1'b0;
  endtask

  task automatic pulse_clr();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  task automatic t_power_up();
    do_reset(2'b00);
    check("R1 rst after reset", lvd_rst, 1'b1);
    check("R1 irq after reset", lvd_irq, 1'b0);
    det = 1'b1; hi = 1'b1; lo = 1'b1;
    repeat (4) @(negedge clk);
    check("R1/R10 rst held without sample", lvd_rst, 1'b1);
  endtask

  task automatic t_reset_mode();
    do_reset(2'b00);
    smp(1, 0, 0, 0); check("R2 release above", lvd_rst, 1'b0);
    smp(0, 0, 0, 0); check("R2 assert below", lvd_rst, 1'b1);
    check("R2 no irq", lvd_irq, 1'b0);
    smp(1, 0, 0, 0); check("R2 release again", lvd_rst, 1'b0);
    det = 1'b0; repeat (3) @(negedge clk);
    check("R10 unsampled drop ignored", lvd_rst, 1'b0);
  endtask

  task automatic t_warn_mode();
    do_reset(2'b01);
    smp(0, 1, 1, 0); check("R4 release above high", lvd_rst, 1'b0);
    check("R5 no irq yet", lvd_irq, 1'b0);
    smp(0, 0, 1, 0); check("R5 irq on high fall", lvd_irq, 1'b1);
    check("R3 band keeps rst low", lvd_rst, 1'b0);
    pulse_clr(); check("R8 clear", lvd_irq, 1'b0);
    smp(0, 0, 0, 0); check("R3 trip below low", lvd_rst, 1'b1);
    check("R5 no second irq without rise", lvd_irq, 1'b0);
    smp(0, 0, 1, 0); check("R4 band holds reset", lvd_rst, 1'b1);
    smp(0, 1, 1, 0); check("R4 released above high", lvd_rst, 1'b0);
    smp(0, 0, 1, 1); check("R8 event beats clear", lvd_irq, 1'b1);
    repeat (3) @(negedge clk);
    check("R8 sticky", lvd_irq, 1'b1);
  endtask

  task automatic t_irq_mode();
    do_reset(2'b10);
    smp(0, 0, 0, 0); check("R6 held below", lvd_rst, 1'b1);
    check("R7 no irq before release", lvd_irq, 1'b0);
    smp(1, 0, 0, 0); check("R6 released", lvd_rst, 1'b0);
    check("R7 no irq on release sample", lvd_irq, 1'b0);
    smp(0, 0, 0, 0); check("R6 no reassert", lvd_rst, 1'b0);
    check("R7 irq on fall", lvd_irq, 1'b1);
    pulse_clr(); check("R8 clear in irq mode", lvd_irq, 1'b0);
    smp(0, 0, 0, 0); check("R7 no irq without crossing", lvd_irq, 1'b0);
    smp(1, 0, 0, 0); check("R7 irq on rise", lvd_irq, 1'b1);
  endtask

  task automatic t_off_mode();
    @(negedge clk); mode = 2'b11;
    @(negedge clk); check("R9 irq forced off", lvd_irq, 1'b0);
    do_reset(2'b11);
    smp(0, 0, 0, 0); check("R9 rst inactive", lvd_rst, 1'b0);
    check("R9 irq inactive", lvd_irq, 1'b0);
  endtask

  initial begin
    #4_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_power_up();
    t_reset_mode();
    t_warn_mode();
    t_irq_mode();
    t_off_mode();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule